// File: doc/BRIEF.md
# Serial ADC Host Reader

This block is the host-side master for a 10-bit serial-output analog-to-digital converter. It drives the converter's active-low chip select and its serial clock. It samples the converter's data line and rebuilds each 10-bit result. Every word it returns is the outcome of the conversion before the current frame, because the converter shifts out its previous result while it samples its input for the next one.

A user starts a frame with a one-cycle `start_i` while `ready_o` is high. The same cycle presents the frame settings: the chip-select policy, the requested frame length, the clock divider and the conversion wait. The reader latches these settings at the start. In release mode, chip select rises after every frame, and the converter presents its MSB on the next falling edge of chip select. In hold mode, chip select stays low between frames, so the reader waits a programmable number of system cycles before the next frame can begin. This gives the converter time to finish converting and to present its next MSB.

The serial clock is the system clock divided down. Each frame carries 10 to 16 clock pulses, and only the first ten carry data.

Top module: `adc_serial_reader`

## Requirements
- R1: During and after reset, `cs_n_o` is 1, `sclk_o` is 0, `ready_o` is 1 and `valid_o` is 0.
- R2: A frame starts only when `start_i` is 1 while `ready_o` is 1. `ready_o` drops in the next cycle. The settings are latched at the start: `start_i` held high during a frame, or settings changed during a frame, have no effect on that frame.
- R3: Let N be `div_i`, with 0 taken as 1. Each high phase and each low phase of `sclk_o` lasts N system cycles. Chip select is low for N cycles before the first rising edge of `sclk_o`.
- R4: The effective frame length is the number of `sclk_o` pulses. In release mode it is `frame_len_i` clamped to the range 10 to 16. In hold mode it is 10 when `frame_len_i` is 10 or less, and 16 otherwise.
- R5: `sdo_i` is sampled on the system edge where `sclk_o` rises, for the first ten pulses only. The first sample becomes bit 9 (the MSB) of `result_o` and the tenth becomes bit 0. Samples taken after the tenth pulse are discarded.
- R6: In release mode, `cs_n_o` falls in the cycle after the start. It rises in the cycle after the low phase that follows the last `sclk_o` pulse, which is the same cycle in which `valid_o` is high and `ready_o` returns.
- R7: In hold mode, `cs_n_o` stays low after the frame. `ready_o` returns only after a wait of `wait_i` cycles, with 0 taken as 1, and `cs_n_o` stays low while the reader is idle.
- R8: If a release-mode frame starts while chip select is being held low, `cs_n_o` first goes high for N cycles and then falls. A hold-mode start in the same situation keeps `cs_n_o` low throughout.
- R9: `valid_o` is high for exactly one cycle per frame, in the first cycle after the final low phase. `result_o` carries the new word in that cycle.
- R10: `stale_o` is 1 with the first result after reset and 0 with every later result.
- R11: `sclk_o` never rises unless `cs_n_o` was already low in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Frame request, accepted while ready_o is 1 |
| hold_i | input | 1 | 1: keep chip select low between frames; 0: release it |
| frame_len_i | input | LEN_W (5) | Requested serial clock count per frame |
| div_i | input | DIV_W (8) | Serial clock half-period in system cycles |
| wait_i | input | WAIT_W (16) | Conversion wait in system cycles (hold mode) |
| ready_o | output | 1 | Reader idle, can accept start_i |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Converter serial clock |
| sdo_i | input | 1 | Converter serial data |
| result_o | output | DATA_W (10) | Recovered word, MSB first on the line |
| valid_o | output | 1 | One-cycle strobe for result_o |
| stale_o | output | 1 | result_o is the undefined conversion before reset |

## Verification
Embedded assertions check several rules on every cycle:
- chip select is low before any serial clock rise;
- the result strobe never lasts two cycles;
- an accepted start drops ready at once;
- the frame length and bit counters stay inside their bounds;
- the divider phase stays below the programmed half-period.

Other behaviour shows only in the bench scenarios, which compare the whole waveform cycle by cycle against a behavioural converter model. These scenarios cover the MSB-first bit order, the discarding of the zero bits after the tenth pulse, the length clamping in both modes, the hold-to-release chip-select bounce, the conversion wait and the stale flag on the first word.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PARK  = 3'd1,
    ST_SETUP = 3'd2,
    ST_HIGH  = 3'd3,
    ST_LOW   = 3'd4,
    ST_WAIT  = 3'd5
  } rd_state_e;

endpackage

// File: rtl/adc_rd_phase.sv
module adc_rd_phase #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             ph_end_o
);

  logic [DIV_W-1:0] ph_q, ph_d;
  logic [DIV_W-1:0] last_ph;

  assign last_ph  = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  assign ph_end_o = run_i && (ph_q == last_ph);

  always_comb begin
    ph_d = ph_q;
    if (!run_i || ph_end_o) ph_d = '0;
    else                    ph_d = ph_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  // R3
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= last_ph);

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              done_i,
  input  logic              sdo_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              stale_o
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              vld_q, vld_d;
  logic              stale_q, stale_d;
  logic              first_q, first_d;

  always_comb begin
    sh_d    = sh_q;
    res_d   = res_q;
    stale_d = stale_q;
    first_d = first_q;
    vld_d   = done_i;
    if (sample_i) sh_d = {sh_q[DATA_W-2:0], sdo_i};
    if (done_i) begin
      res_d   = sh_q;
      stale_d = first_q;
      first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      res_q   <= '0;
      vld_q   <= 1'b0;
      stale_q <= 1'b0;
      first_q <= 1'b1;
    end else begin
      sh_q    <= sh_d;
      res_q   <= res_d;
      vld_q   <= vld_d;
      stale_q <= stale_d;
      first_q <= first_d;
    end
  end

  assign result_o = res_q;
  assign valid_o  = vld_q;
  assign stale_o  = stale_q;

  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R10
  stale_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !first_q && $past(!first_q)) |-> !stale_q);

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int MAX_LEN = 16,
  parameter int DIV_W   = 8,
  parameter int WAIT_W  = 16,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              hold_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              ph_end_i,
  output logic              run_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              ready_o,
  output logic              sample_o,
  output logic              done_o
);

  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(DATA_W);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

  rd_state_e         st_q, st_d;
  logic              held_q, held_d;
  logic              hold_q;
  logic [LEN_W-1:0]  len_q, len_req;
  logic [DIV_W-1:0]  div_q;
  logic [WAIT_W-1:0] wait_q;
  logic [LEN_W-1:0]  bc_q, bc_d;
  logic [WAIT_W-1:0] wc_q, wc_d;
  logic              accept;

  assign accept = (st_q == ST_IDLE) && start_i;

  always_comb begin
    if (hold_i)                    len_req = (frame_len_i <= LEN_MIN) ? LEN_MIN : LEN_MAX;
    else if (frame_len_i < LEN_MIN) len_req = LEN_MIN;
    else if (frame_len_i > LEN_MAX) len_req = LEN_MAX;
    else                            len_req = frame_len_i;
  end

  always_comb begin
    st_d   = st_q;
    held_d = held_q;
    bc_d   = bc_q;
    wc_d   = wc_q;
    case (st_q)
      ST_IDLE: if (start_i) begin
        bc_d = '0;
        if (held_q && !hold_i) begin
          st_d   = ST_PARK;
          held_d = 1'b0;
        end else begin
          st_d = ST_SETUP;
        end
      end
      ST_PARK:  if (ph_end_i) st_d = ST_SETUP;
      ST_SETUP: if (ph_end_i) st_d = ST_HIGH;
      ST_HIGH: if (ph_end_i) begin
        st_d = ST_LOW;
        bc_d = bc_q + LEN_W'(1);
      end
      ST_LOW: if (ph_end_i) begin
        if (bc_q == len_q) begin
          if (hold_q) begin
            st_d   = ST_WAIT;
            held_d = 1'b1;
            wc_d   = '0;
          end else begin
            st_d = ST_IDLE;
          end
        end else begin
          st_d = ST_HIGH;
        end
      end
      ST_WAIT: begin
        if (({1'b0, wc_q} + (WAIT_W+1)'(1)) >= {1'b0, wait_q}) st_d = ST_IDLE;
        else wc_d = wc_q + WAIT_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      held_q <= 1'b0;
      bc_q   <= '0;
      wc_q   <= '0;
    end else begin
      st_q   <= st_d;
      held_q <= held_d;
      bc_q   <= bc_d;
      wc_q   <= wc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      len_q  <= LEN_MIN;
      div_q  <= '0;
      wait_q <= '0;
    end else if (accept) begin
      hold_q <= hold_i;
      len_q  <= len_req;
      div_q  <= div_i;
      wait_q <= wait_i;
    end
  end

  assign run_o    = (st_q == ST_PARK) || (st_q == ST_SETUP) ||
                    (st_q == ST_HIGH) || (st_q == ST_LOW);
  assign div_o    = div_q;
  assign cs_n_o   = (st_q == ST_IDLE) ? !held_q : (st_q == ST_PARK);
  assign sclk_o   = (st_q == ST_HIGH);
  assign ready_o  = (st_q == ST_IDLE);
  assign sample_o = ph_end_i && (bc_q < LEN_MIN) &&
                    ((st_q == ST_SETUP) || ((st_q == ST_LOW) && (bc_q != len_q)));
  assign done_o   = (st_q == ST_LOW) && ph_end_i && (bc_q == len_q);

  // R2
  start_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && start_i) |=> !ready_o);

  // R11
  cs_before_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $past(!cs_n_o));

  // R4
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> (len_q >= LEN_MIN && len_q <= LEN_MAX && bc_q <= len_q));

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int DATA_W  = 10,
  parameter int MAX_LEN = 16,
  parameter int DIV_W   = 8,
  parameter int WAIT_W  = 16,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              hold_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              ready_o,
  output logic              cs_n_o,
  output logic              sclk_o,
  input  logic              sdo_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              stale_o
);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             run, ph_end, sample, done;
  logic [DIV_W-1:0] div_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  adc_rd_ctrl #(
    .DATA_W (DATA_W),
    .MAX_LEN(MAX_LEN),
    .DIV_W  (DIV_W),
    .WAIT_W (WAIT_W),
    .LEN_W  (LEN_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .hold_i     (hold_i),
    .frame_len_i(frame_len_i),
    .div_i      (div_i),
    .wait_i     (wait_i),
    .ph_end_i   (ph_end),
    .run_o      (run),
    .div_o      (div_lat),
    .cs_n_o     (cs_n_o),
    .sclk_o     (sclk_o),
    .ready_o    (ready_o),
    .sample_o   (sample),
    .done_o     (done)
  );

  adc_rd_phase #(.DIV_W(DIV_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run_i   (run),
    .div_i   (div_lat),
    .ph_end_o(ph_end)
  );

  adc_rd_capture #(.DATA_W(DATA_W)) u_capture (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sample_i(sample),
    .done_i  (done),
    .sdo_i   (sdo_i),
    .result_o(result_o),
    .valid_o (valid_o),
    .stale_o (stale_o)
  );

endmodule

// File: tb/adc_serial_reader_bench.sv
module adc_serial_reader_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, hold_i, sdo_i;
  logic [4:0]  frame_len_i;
  logic [7:0]  div_i;
  logic [15:0] wait_i;
  logic        ready_o, cs_n_o, sclk_o, valid_o, stale_o;
  logic [9:0]  result_o;

  always #5 clk = ~clk;

  adc_serial_reader u_adc_serial_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hold_i(hold_i),
    .frame_len_i(frame_len_i), .div_i(div_i), .wait_i(wait_i),
    .ready_o(ready_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdo_i(sdo_i),
    .result_o(result_o), .valid_o(valid_o), .stale_o(stale_o)
  );

  int         checks = 0;
  int         fails  = 0;
  int         eq[$];
  logic [9:0] wq[$];
  int         frame_idx = 0;
  bit         held_exp  = 0;
  bit         run_chk   = 0;
  bit         finished  = 0;
  string      cur_tag   = "R1";

  // converter model state
  logic [9:0] cur_word = '0;
  int         load_idx = 0;
  int         fall_cnt = 0;
  int         idle_cnt = 0;
  logic       prev_cs = 1'b1;
  logic       prev_sclk = 1'b0;

  function automatic logic [9:0] word_of(input int k);
    return 10'((k * 173 + 'h2A5) & 'h3FF);
  endfunction

  function automatic int code(input bit cs, input bit sc, input bit rdy, input bit vld);
    return int'(cs) | (int'(sc) << 1) | (int'(rdy) << 2) | (int'(vld) << 3);
  endfunction

  task automatic report_fail(input string req, input string what, input int act, input int exp);
    fails++;
    $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
  endtask

  task automatic load_word();
    cur_word = word_of(load_idx);
    load_idx++;
    fall_cnt = 0;
    idle_cnt = 0;
    sdo_i    = cur_word[9];
  endtask

  // reference comparison and converter model, every clock
  always @(negedge clk) begin
    int e, a;
    if (run_chk && !finished) begin
      e = (eq.size() > 0) ? eq.pop_front() : code(!held_exp, 0, 1, 0);
      a = code(cs_n_o, sclk_o, ready_o, valid_o);
      checks++;
      if (a != e) report_fail(cur_tag, "waveform {vld,rdy,sclk,cs_n}", a, e);
      if ((e & 8) != 0) begin
        logic [9:0] w;
        w = (wq.size() > 0) ? wq.pop_front() : 10'h000;
        checks++;
        if (result_o !== w) report_fail("R5 R9", "result_o", int'(result_o), int'(w));
        checks++;
        if (stale_o !== (frame_idx == 0)) report_fail("R10", "stale_o", int'(stale_o), int'(frame_idx == 0));
        frame_idx++;
      end
    end
    // converter behaviour
    if (cs_n_o) begin
      fall_cnt = 0; idle_cnt = 0; sdo_i = 1'b0;
    end else if (prev_cs) begin
      load_word();
    end else begin
      if (!prev_sclk && sclk_o && fall_cnt == 0) wq.push_back(cur_word);
      if (prev_sclk && !sclk_o) begin
        fall_cnt++;
        idle_cnt = 0;
        sdo_i = (fall_cnt >= 10) ? 1'b0 : cur_word[9 - fall_cnt];
      end else if (!sclk_o) begin
        idle_cnt++;
        if (fall_cnt >= 10 && idle_cnt >= 8) load_word();
      end
    end
    prev_cs   = cs_n_o;
    prev_sclk = sclk_o;
  end

  task automatic run_frame(input bit h, input int len_req, input int dv, input int wt,
                           input int extra, input string tag);
    int n, len, w;
    n = (dv == 0) ? 1 : dv;
    w = (wt == 0) ? 1 : wt;
    if (h) len = (len_req <= 10) ? 10 : 16;
    else   len = (len_req < 10) ? 10 : ((len_req > 16) ? 16 : len_req);
    @(posedge clk); #1;
    cur_tag     = tag;
    start_i     = 1'b1;
    hold_i      = h;
    frame_len_i = 5'(len_req);
    div_i       = 8'(dv);
    wait_i      = 16'(wt);
    eq.push_back(code(!held_exp, 0, 1, 0));
    if (held_exp && !h) for (int i = 0; i < n; i++) eq.push_back(code(1, 0, 0, 0));
    for (int i = 0; i < n; i++) eq.push_back(code(0, 0, 0, 0));
    for (int p = 0; p < len; p++) begin
      for (int i = 0; i < n; i++) eq.push_back(code(0, 1, 0, 0));
      for (int i = 0; i < n; i++) eq.push_back(code(0, 0, 0, 0));
    end
    if (!h) begin
      eq.push_back(code(1, 0, 1, 1));
      held_exp = 0;
    end else begin
      eq.push_back(code(0, 0, 0, 1));
      for (int i = 1; i < w; i++) eq.push_back(code(0, 0, 0, 0));
      held_exp = 1;
    end
    repeat (1 + extra) @(posedge clk);
    #1;
    start_i = 1'b0;
    // R2: settings changed mid-frame must not matter
    frame_len_i = 5'd31;
    div_i       = 8'd7;
    wait_i      = 16'd3;
    hold_i      = !h;
    while (eq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; hold_i = 1'b0; sdo_i = 1'b0;
    frame_len_i = 5'd10; div_i = 8'd1; wait_i = 16'd12;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++; if (cs_n_o !== 1'b1) report_fail("R1", "cs_n_o", int'(cs_n_o), 1);
    checks++; if (sclk_o !== 1'b0) report_fail("R1", "sclk_o", int'(sclk_o), 0);
    checks++; if (ready_o !== 1'b1) report_fail("R1", "ready_o", int'(ready_o), 1);
    checks++; if (valid_o !== 1'b0) report_fail("R1", "valid_o", int'(valid_o), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    run_chk = 1;
    run_frame(0, 10, 1, 0, 0, "R6 R10");
    run_frame(0, 13, 2, 0, 2, "R2 R3");
    run_frame(0, 16, 3, 0, 0, "R3 R5");
    run_frame(0, 7, 1, 0, 0, "R4");
    run_frame(0, 20, 2, 0, 0, "R4");
    run_frame(1, 10, 2, 12, 0, "R7");
    run_frame(1, 10, 1, 12, 1, "R7 R9");
    run_frame(1, 13, 2, 15, 0, "R4 R7");
    run_frame(0, 11, 1, 0, 0, "R8");
    run_frame(1, 16, 1, 14, 0, "R7 R11");
    run_frame(1, 12, 2, 12, 0, "R4 R8");
    run_frame(0, 12, 0, 0, 0, "R3 R8");
    run_frame(0, 10, 1, 0, 0, "R9");
    checks++;
    if (frame_idx != 13) report_fail("R9", "frame count", frame_idx, 13);
    finish_run();
  end

endmodule